// File: doc/BRIEF.md
# Inbound Unsupported Request Handler

This block sits on the inbound request path between the downstream link and the host memory path. Memory reads and writes from the link pass through in the same cycle, unchanged. I/O and configuration requests are not supported inbound. The block still answers them: it rewrites each one as a memory read of the fixed legacy address `0x000C_0000` and keeps the original requester tag. The memory path then produces a completion in its normal way, as it would for any read.

The tags of these rewritten requests are held in a small table of outstanding entries. When a completion with a recorded tag returns from the memory path, the block changes its status to Unsupported Request and strips its data. It then frees the table entry. Completions for any other tag pass through untouched. When the table is full, the block stops accepting unsupported requests until an entry frees, and memory traffic continues to flow. Requesters keep tags unique among outstanding requests.

Top module: `inb_unsup_handler`

## Requirements
- R1: Request kinds 0 (memory read) and 1 (memory write) are presented on the memory request port in the same cycle, with address, tag and data unchanged. `mreq_we_o` is 1 only for kind 1.
- R2: Request kinds 2 (I/O read) and 3 (I/O write) are presented as a read (`mreq_we_o`=0) of address `0x000C_0000`, with the original tag and zero data. A write is rewritten as a read in the same way.
- R3: Kinds 4 and 5 (configuration read/write) and the reserved kinds 6 and 7 get the same rewrite as R2.
- R4: `req_ready_o` follows `mreq_ready_i` whenever the request may pass. No request is accepted while `mreq_ready_i` is 0.
- R5: Every accepted rewritten request records its tag. A later completion with that tag leaves the block in the same cycle with status 3'b001 (Unsupported Request), `cpl_has_data_o`=0 and zero data, and the entry is freed.
- R6: With ENTRIES rewritten requests outstanding, unsupported requests are held off (`req_ready_o`=0 and `mreq_valid_o`=0) while memory requests still pass. A freed entry allows acceptance from the next cycle.
- R7: A completion whose tag is not outstanding passes in the same cycle with tag, status, data flag and data unchanged.
- R8: After reset the table is empty, and no output is valid while no input is valid.
- R9: Once an entry is freed, a second completion with the same tag passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Inbound request valid |
| req_ready_o | output | 1 | Inbound request accepted |
| req_kind_i | input | 3 | Request kind code (see R1-style codes in requirements) |
| req_addr_i | input | ADDR_W | Request address |
| req_tag_i | input | TAG_W | Requester tag |
| req_data_i | input | DATA_W | Write data |
| mreq_valid_o | output | 1 | Memory path request valid |
| mreq_ready_i | input | 1 | Memory path ready |
| mreq_we_o | output | 1 | Memory path write enable |
| mreq_addr_o | output | ADDR_W | Memory path address |
| mreq_tag_o | output | TAG_W | Memory path tag |
| mreq_data_o | output | DATA_W | Memory path write data |
| cpl_valid_i | input | 1 | Completion from memory path valid |
| cpl_tag_i | input | TAG_W | Completion tag |
| cpl_status_i | input | 3 | Completion status |
| cpl_has_data_i | input | 1 | Completion carries data |
| cpl_data_i | input | DATA_W | Completion data |
| cpl_valid_o | output | 1 | Completion toward link valid |
| cpl_tag_o | output | TAG_W | Completion tag out |
| cpl_status_o | output | 3 | Completion status out |
| cpl_has_data_o | output | 1 | Completion data flag out |
| cpl_data_o | output | DATA_W | Completion data out |

## Verification
The assertions check the following on every cycle:
- a memory request leaves unmodified;
- every rewritten request targets the legacy address as a read;
- nothing is recorded in a full table;
- a recorded completion always leaves as Unsupported Request with no data;
- an accepted unsupported request adds exactly one entry.

Only the bench scenarios can show the following, because they depend on history across many cycles:
- the table fills at the right count;
- acceptance resumes one cycle after a completion frees an entry;
- a request offered in the same cycle as a freeing completion is still held off;
- a tag whose entry has been freed reverts to pass-through.

// File: rtl/inb_unsup_pkg.sv
package inb_unsup_pkg;
  localparam logic [2:0] K_MEM_RD = 3'd0;
  localparam logic [2:0] K_MEM_WR = 3'd1;
  localparam logic [2:0] ST_UR    = 3'b001;

  function automatic logic is_mem_kind(input logic [2:0] kind);
    return (kind == K_MEM_RD) || (kind == K_MEM_WR);
  endfunction
endpackage

// File: rtl/inb_req_steer.sv
module inb_req_steer
  import inb_unsup_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter logic [ADDR_W-1:0] REDIR_ADDR = ADDR_W'(32'h000C_0000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              table_full_i,
  output logic              alloc_o,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic              mreq_we_o,
  output logic [ADDR_W-1:0] mreq_addr_o,
  output logic [TAG_W-1:0]  mreq_tag_o,
  output logic [DATA_W-1:0] mreq_data_o
);
  logic is_mem, may_pass;

  always_comb begin
    is_mem       = is_mem_kind(req_kind_i);
    may_pass     = is_mem || !table_full_i;
    mreq_valid_o = req_valid_i && may_pass;
    req_ready_o  = mreq_ready_i && may_pass;
    alloc_o      = req_valid_i && mreq_ready_i && !is_mem && !table_full_i;
    mreq_we_o    = is_mem && (req_kind_i == K_MEM_WR);
    mreq_addr_o  = is_mem ? req_addr_i : REDIR_ADDR;
    mreq_data_o  = is_mem ? req_data_i : '0;
    mreq_tag_o   = req_tag_i;
  end

  assert_mem_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_valid_o && is_mem_kind(req_kind_i) |->
      mreq_addr_o == req_addr_i && mreq_data_o == req_data_i && mreq_tag_o == req_tag_i);

  assert_redirect_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_valid_o && !is_mem_kind(req_kind_i) |->
      mreq_addr_o == REDIR_ADDR && !mreq_we_o && mreq_tag_o == req_tag_i);

  assert_ready_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_ready_i |-> !req_ready_o && !alloc_o);
endmodule

// File: rtl/inb_tag_table.sv
module inb_tag_table #(
  parameter int TAG_W   = 8,
  parameter int ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic             lookup_valid_i,
  input  logic [TAG_W-1:0] lookup_tag_i,
  output logic             hit_o,
  output logic             full_o
);
  logic [ENTRIES-1:0] vld_q, match, sel;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  // lowest free slot
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld_q[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = vld_q[g] && lookup_valid_i && (tag_q[g] == lookup_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (alloc_i && sel[g]) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= alloc_tag_i;
      end else if (match[g]) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  assign hit_o  = |match;
  assign full_o = &vld_q;

  assert_no_alloc_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !alloc_i);

  assert_alloc_adds_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && !hit_o |=> $countones(vld_q) == $past($countones(vld_q)) + 1);

  assert_unique_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/inb_cpl_rewrite.sv
module inb_cpl_rewrite
  import inb_unsup_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              cpl_valid_i,
  input  logic [TAG_W-1:0]  cpl_tag_i,
  input  logic [2:0]        cpl_status_i,
  input  logic              cpl_has_data_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  output logic              cpl_valid_o,
  output logic [TAG_W-1:0]  cpl_tag_o,
  output logic [2:0]        cpl_status_o,
  output logic              cpl_has_data_o,
  output logic [DATA_W-1:0] cpl_data_o
);
  always_comb begin
    cpl_valid_o    = cpl_valid_i;
    cpl_tag_o      = cpl_tag_i;
    cpl_status_o   = hit_i ? ST_UR : cpl_status_i;
    cpl_has_data_o = hit_i ? 1'b0  : cpl_has_data_i;
    cpl_data_o     = hit_i ? '0    : cpl_data_i;
  end

  assert_ur_no_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && hit_i |-> cpl_status_o == ST_UR && !cpl_has_data_o && cpl_data_o == '0);

  assert_cpl_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && !hit_i |-> cpl_status_o == cpl_status_i && cpl_data_o == cpl_data_i);
endmodule

// File: rtl/inb_unsup_handler.sv
module inb_unsup_handler
  import inb_unsup_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 8,
  parameter int ENTRIES = 8,
  parameter logic [ADDR_W-1:0] REDIR_ADDR = ADDR_W'(32'h000C_0000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic              mreq_we_o,
  output logic [ADDR_W-1:0] mreq_addr_o,
  output logic [TAG_W-1:0]  mreq_tag_o,
  output logic [DATA_W-1:0] mreq_data_o,
  input  logic              cpl_valid_i,
  input  logic [TAG_W-1:0]  cpl_tag_i,
  input  logic [2:0]        cpl_status_i,
  input  logic              cpl_has_data_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  output logic              cpl_valid_o,
  output logic [TAG_W-1:0]  cpl_tag_o,
  output logic [2:0]        cpl_status_o,
  output logic              cpl_has_data_o,
  output logic [DATA_W-1:0] cpl_data_o
);
  logic alloc, full, hit;

  inb_req_steer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .REDIR_ADDR(REDIR_ADDR)
  ) u_steer (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_kind_i, .req_addr_i, .req_tag_i, .req_data_i,
    .table_full_i(full), .alloc_o(alloc),
    .mreq_valid_o, .mreq_ready_i, .mreq_we_o, .mreq_addr_o, .mreq_tag_o, .mreq_data_o
  );

  inb_tag_table #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_table (
    .clk_i, .rst_ni,
    .alloc_i(alloc), .alloc_tag_i(req_tag_i),
    .lookup_valid_i(cpl_valid_i), .lookup_tag_i(cpl_tag_i),
    .hit_o(hit), .full_o(full)
  );

  inb_cpl_rewrite #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cpl (
    .clk_i, .rst_ni, .hit_i(hit),
    .cpl_valid_i, .cpl_tag_i, .cpl_status_i, .cpl_has_data_i, .cpl_data_i,
    .cpl_valid_o, .cpl_tag_o, .cpl_status_o, .cpl_has_data_o, .cpl_data_o
  );

  assert_full_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && req_valid_i && !is_mem_kind(req_kind_i) |-> !req_ready_o && !mreq_valid_o);

  assert_idle_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i && !cpl_valid_i |-> !mreq_valid_o && !cpl_valid_o);
endmodule

// File: tb/inb_unsup_handler_tb.sv
module inb_unsup_handler_tb_top;
  localparam int CLK_P  = 10;
  localparam int AW     = 32;
  localparam int DW     = 32;
  localparam int TW     = 4;
  localparam int ENT    = 4;
  localparam logic [AW-1:0] REDIR = 32'h000C_0000;

  logic clk = 0, rst_ni = 0;
  logic req_valid_i = 0, mreq_ready_i = 1, cpl_valid_i = 0, cpl_has_data_i = 0;
  logic [2:0] req_kind_i = 0, cpl_status_i = 0;
  logic [AW-1:0] req_addr_i = 0;
  logic [TW-1:0] req_tag_i = 0, cpl_tag_i = 0;
  logic [DW-1:0] req_data_i = 0, cpl_data_i = 0;
  logic req_ready_o, mreq_valid_o, mreq_we_o, cpl_valid_o, cpl_has_data_o;
  logic [AW-1:0] mreq_addr_o;
  logic [TW-1:0] mreq_tag_o, cpl_tag_o;
  logic [DW-1:0] mreq_data_o, cpl_data_o;
  logic [2:0] cpl_status_o;

  always #(CLK_P/2) clk = ~clk;

  inb_unsup_handler #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .ENTRIES(ENT)) dut_i (
    .clk_i(clk), .rst_ni,
    .req_valid_i, .req_ready_o, .req_kind_i, .req_addr_i, .req_tag_i, .req_data_i,
    .mreq_valid_o, .mreq_ready_i, .mreq_we_o, .mreq_addr_o, .mreq_tag_o, .mreq_data_o,
    .cpl_valid_i, .cpl_tag_i, .cpl_status_i, .cpl_has_data_i, .cpl_data_i,
    .cpl_valid_o, .cpl_tag_o, .cpl_status_o, .cpl_has_data_o, .cpl_data_o
  );

  int errs = 0, checks = 0, cnt = 0;
  bit outs [16];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive request; returns after the clock edge
  task automatic send(input logic [2:0] kind, input logic [AW-1:0] a,
                      input logic [TW-1:0] t, input logic [DW-1:0] d,
                      input bit rdy, input string req);
    bit mem, pass, acc;
    @(negedge clk);
    req_valid_i = 1; req_kind_i = kind; req_addr_i = a; req_tag_i = t;
    req_data_i = d; mreq_ready_i = rdy;
    #1;
    mem  = (kind < 2);
    pass = mem || (cnt < ENT);
    acc  = rdy && pass;
    chk(req_ready_o == acc, req, "req_ready", req_ready_o, acc);
    chk(mreq_valid_o == pass, req, "mreq_valid", mreq_valid_o, pass);
    if (pass) begin
      chk(mreq_addr_o == (mem ? a : REDIR), req, "addr", mreq_addr_o, mem ? a : REDIR);
      chk(mreq_we_o == (kind == 1), req, "we", mreq_we_o, kind == 1);
      chk(mreq_data_o == (mem ? d : '0), req, "data", mreq_data_o, mem ? d : '0);
      chk(mreq_tag_o == t, req, "tag", mreq_tag_o, t);
    end
    @(posedge clk);
    if (acc && !mem) begin outs[t] = 1; cnt++; end
    #1 req_valid_i = 0; mreq_ready_i = 1;
  endtask

  task automatic cpl(input logic [TW-1:0] t, input logic [2:0] st,
                     input logic [DW-1:0] d, input bit hd, input string req);
    bit h;
    @(negedge clk);
    cpl_valid_i = 1; cpl_tag_i = t; cpl_status_i = st; cpl_data_i = d; cpl_has_data_i = hd;
    #1;
    h = outs[t];
    chk(cpl_valid_o == 1, req, "cpl_valid", cpl_valid_o, 1);
    chk(cpl_tag_o == t, req, "cpl_tag", cpl_tag_o, t);
    chk(cpl_status_o == (h ? 3'b001 : st), req, "cpl_status", cpl_status_o, h ? 3'b001 : st);
    chk(cpl_has_data_o == (h ? 1'b0 : hd), req, "cpl_has_data", cpl_has_data_o, h ? 1'b0 : hd);
    chk(cpl_data_o == (h ? '0 : d), req, "cpl_data", cpl_data_o, h ? '0 : d);
    @(posedge clk);
    if (h) begin outs[t] = 0; cnt--; end
    #1 cpl_valid_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk(mreq_valid_o == 0, "R8", "idle mreq_valid", mreq_valid_o, 0);
    chk(cpl_valid_o == 0, "R8", "idle cpl_valid", cpl_valid_o, 0);

    // round A: all kinds, fills table, then overflows (R1 R2 R3 R6)
    for (int t = 0; t < 16; t++)
      send(3'(t % 8), 32'h1000_0000 + 32'(t * 'h44), 4'(t), 32'hA5A5_0000 | 32'(t), 1,
           (t % 8 < 2) ? "R1" : (t % 8 < 4) ? "R2" : (t % 8 < 6) ? "R3" : "R6");
    chk(cnt == ENT, "R6", "model fill", cnt, ENT);

    // completions for every tag (R5 R7)
    for (int t = 0; t < 16; t++)
      cpl(4'(t), (t % 2) ? 3'b100 : 3'b000, 32'hD000_0000 | 32'(t), 1,
          outs[t] ? "R5" : "R7");

    // ready low: nothing accepted (R4)
    for (int k = 0; k < 8; k++)
      send(3'(k), 32'h2000_0000 | 32'(k), 4'(k), 32'(k), 0, "R4");

    // refill, same-cycle free + request held off, then recovery (R6 R9)
    for (int t = 0; t < ENT; t++) send(3'd3, 32'h30, 4'(t), 32'h1, 1, "R2");
    @(negedge clk);
    req_valid_i = 1; req_kind_i = 3'd2; req_tag_i = 4'd9; req_addr_i = 32'h44;
    cpl_valid_i = 1; cpl_tag_i = 4'd0; cpl_status_i = 3'b000; cpl_has_data_i = 1;
    cpl_data_i = 32'h55;
    #1;
    chk(req_ready_o == 0, "R6", "held off while freeing", req_ready_o, 0);
    chk(cpl_status_o == 3'b001, "R5", "same-cycle UR", cpl_status_o, 3'b001);
    @(posedge clk);
    outs[0] = 0; cnt--;
    #1 req_valid_i = 0; cpl_valid_i = 0;
    send(3'd2, 32'h44, 4'd9, 32'h0, 1, "R6");
    cpl(4'd0, 3'b010, 32'h77, 1, "R9");
    cpl(4'd9, 3'b000, 32'h88, 1, "R5");
    for (int t = 1; t < ENT; t++) cpl(4'(t), 3'b000, 32'h9, 1, "R5");

    // near-exhaustive sweep: every kind x several addresses, completed at once
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 4; a++) begin
        send(3'(k), 32'(a) << (8 * a) | 32'h0000_0003, 4'(k + a), 32'hBEEF_0000 | 32'(a), 1,
             (k < 2) ? "R1" : (k < 4) ? "R2" : "R3");
        cpl(4'(k + a), 3'(a), 32'hC0DE_0000 | 32'(k), a[0], (k < 2) ? "R7" : "R5");
      end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule